// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Processor Core

This block is a 32-bit processor core that completes one instruction on every rising clock edge. Each cycle it presents a word address to an external instruction memory, decodes the returned instruction, reads two source registers, and computes a result in a three-function ALU. In the same cycle it either writes a register, writes its internal data memory, or changes the program counter. Only seven operations are recognised: register add and subtract, OR with an immediate, word load, word store, branch-if-equal and an absolute jump. Any other encoding retires as a no-op.

The core holds a 32-entry register file whose entry 0 is hard-wired to zero. It also holds a small word-organised data memory with synchronous write and combinational read. A debug port exposes the current program counter and the register write that the current instruction will commit at the next edge, so a surrounding environment can trace execution without reaching into the core.

Top module: `tiny_cpu`

## Requirements
- R1: While `rst_n` is low on a rising edge, the PC, every register and every data-memory word are cleared to zero.
- R2: `imem_addr` equals PC bits [IMEM_AW+1:2] and `dbg_pc` equals the PC. Except for a taken branch or a jump, each instruction advances the PC by 4.
- R3: Opcode 000000 (instr[31:26]) is the register format, with rs = instr[25:21], rt = instr[20:16], rd = instr[15:11] and funct = instr[5:0]. Funct 100000 writes rs+rt to rd, and funct 100010 writes rs-rt to rd, both modulo 2^32.
- R4: Opcode 001101 writes rs OR the zero-extended instr[15:0] to rt.
- R5: Opcode 100011 writes to rt the data word at rs + sign-extended instr[15:0]. The word is selected by address bits [DMEM_AW+1:2], and the other address bits are ignored.
- R6: Opcode 101011 stores the value of rt at the word addressed as in R5 and writes no register.
- R7: Opcode 000100 writes nothing. If rs equals rt, the next PC is PC+4 plus the sign-extended instr[15:0] shifted left by two; otherwise the next PC is PC+4.
- R8: Opcode 000010 writes nothing. The next PC is {PC[31:28], instr[25:0], 2'b00}.
- R9: A write aimed at register 0 is dropped (`dbg_wr_en` stays low), and register 0 always reads as zero.
- R10: Any other opcode, or opcode 000000 with any other funct, writes nothing and advances the PC by 4.
- R11: `dbg_wr_en`, `dbg_wr_idx` and `dbg_wr_data` describe the register write that the current instruction commits at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | IMEM_AW | Word address of the instruction to fetch |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dbg_pc | output | 32 | Current program counter |
| dbg_wr_en | output | 1 | Current instruction writes a nonzero register |
| dbg_wr_idx | output | 5 | Destination register of that write |
| dbg_wr_data | output | 32 | Value being written |

## Verification
The bench builds the core with a 256-word fetch window (IMEM_AW = 8) and a 16-word data memory. With a memory that small, random load and store addresses alias onto the same words often, so stores followed by loads of the same word happen many times in each program. Short signed branch offsets can move the PC below zero into the upper address space, where a jump must keep the top four PC bits. Pseudo-random programs of every instruction kind, including unknown encodings and writes to register 0, each run for hundreds of cycles. They are compared at every cycle against an instruction-level model in the bench, and each new program starts from a reset so that clearing of registers and memory is also observed.

// File: rtl/tcpu_pkg.sv
// Package: shared encodings and the control-word type of the core.
// Assumes 32-bit instructions with the opcode in bits [31:26].
package tcpu_pkg;
    localparam int WORD_W = 32;
    localparam int RIDX_W = 5;

    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_ORI   = 6'b001101;
    localparam logic [5:0] OP_LW    = 6'b100011;
    localparam logic [5:0] OP_SW    = 6'b101011;
    localparam logic [5:0] OP_BEQ   = 6'b000100;
    localparam logic [5:0] OP_JMP   = 6'b000010;
    localparam logic [5:0] FN_ADD   = 6'b100000;
    localparam logic [5:0] FN_SUB   = 6'b100010;

    typedef enum logic [1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01,
        ALU_OR  = 2'b10
    } alu_op_e;

    typedef struct packed {
        logic    rf_we;     // commit a register write
        logic    dst_rd;    // destination is rd (else rt)
        logic    src_imm;   // ALU operand B is the extended immediate
        logic    sext;      // sign-extend the immediate (else zero-extend)
        logic    mem_to_rf; // write-back from data memory
        logic    mem_we;    // write data memory
        logic    is_beq;    // conditional branch
        logic    is_jmp;    // absolute jump
        alu_op_e alu_op;
    } ctrl_t;
endpackage

// File: rtl/tcpu_decode.sv
// Main decoder: maps opcode and funct onto the datapath control word.
// Unknown encodings give an all-inactive control word (a no-op).
module tcpu_decode
    import tcpu_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    // Purpose: one case per recognised opcode, defaults are inactive.
    always_comb begin
        ctrl = '0;
        ctrl.alu_op = ALU_ADD;
        case (op)
            OP_RTYPE: begin
                ctrl.dst_rd = 1'b1;
                if (funct == FN_ADD) begin
                    ctrl.rf_we = 1'b1;
                end else if (funct == FN_SUB) begin
                    ctrl.rf_we  = 1'b1;
                    ctrl.alu_op = ALU_SUB;
                end
            end
            OP_ORI: begin
                ctrl.rf_we   = 1'b1;
                ctrl.src_imm = 1'b1;
                ctrl.alu_op  = ALU_OR;
            end
            OP_LW: begin
                ctrl.rf_we     = 1'b1;
                ctrl.src_imm   = 1'b1;
                ctrl.sext      = 1'b1;
                ctrl.mem_to_rf = 1'b1;
            end
            OP_SW: begin
                ctrl.src_imm = 1'b1;
                ctrl.sext    = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OP_BEQ: begin
                ctrl.is_beq = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OP_JMP:  ctrl.is_jmp = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/tcpu_regfile.sv
// Register file: two combinational read ports, one write port on the rising edge.
// Entry 0 is a constant zero; writes to it are dropped. Synchronous active-low reset.
module tcpu_regfile #(
    parameter int NREG  = 32,
    parameter int W     = 32,
    localparam int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);
    logic [W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign regs[g] = '0;
        end else begin : g_store
            logic [W-1:0] q;
            // Purpose: hold one architectural register.
            always_ff @(posedge clk) begin
                if (!rst_n)                       q <= '0;
                else if (we && wa == AW'(g))      q <= wd;
            end
            assign regs[g] = q;
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];
endmodule

// File: rtl/tcpu_alu.sv
// Three-function ALU (add, subtract, OR) with an equality flag taken from the result.
// The flag is only meaningful when the subtract function is selected.
module tcpu_alu
    import tcpu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         eq
);
    // Purpose: select the result of the requested function.
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end

    assign eq = (y == '0);
endmodule

// File: rtl/tcpu_dmem.sv
// Data memory: word array with write on the rising edge and combinational read.
// Assumes the caller passes only the word-index bits of the address. Cleared by reset.
module tcpu_dmem #(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [W-1:0]  wd,
    output logic [W-1:0]  rd
);
    logic [W-1:0] mem [DEPTH];

    // Purpose: clear on reset, otherwise write the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= wd;
        end
    end

    assign rd = mem[idx];
endmodule

// File: rtl/tiny_cpu.sv
// Top: single-cycle core. One instruction retires per clock; the fetch port is
// combinational (instruction must be valid in the same cycle as imem_addr).
// Synchronous active-low reset puts the PC at zero.
module tiny_cpu
    import tcpu_pkg::*;
#(
    parameter int IMEM_AW    = 10,
    parameter int DMEM_DEPTH = 64,
    parameter int NREG       = 32,
    localparam int DMEM_AW   = $clog2(DMEM_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [IMEM_AW-1:0] imem_addr,
    input  logic [31:0]        imem_data,
    output logic [31:0]        dbg_pc,
    output logic               dbg_wr_en,
    output logic [4:0]         dbg_wr_idx,
    output logic [31:0]        dbg_wr_data
);
    logic [WORD_W-1:0] pc_q, pc_next, pc_plus4, br_target, jmp_target;
    logic [WORD_W-1:0] imm_ext, br_off, src_a, src_b, alu_b, alu_y, mem_rd, wb_data;
    logic [RIDX_W-1:0] rs, rt, rd, wr_idx;
    logic [15:0]       imm16;
    logic              alu_eq, dmem_we;
    logic              unused_shamt;
    ctrl_t             ctrl;

    assign rs           = imem_data[25:21];
    assign rt           = imem_data[20:16];
    assign rd           = imem_data[15:11];
    assign imm16        = imem_data[15:0];
    assign unused_shamt = ^imem_data[10:6];

    tcpu_decode u_dec (
        .op    (imem_data[31:26]),
        .funct (imem_data[5:0]),
        .ctrl  (ctrl)
    );

    tcpu_regfile #(.NREG(NREG), .W(WORD_W)) u_rf (
        .clk (clk),
        .rst_n (rst_n),
        .ra1 (rs),
        .ra2 (rt),
        .we  (ctrl.rf_we),
        .wa  (wr_idx),
        .wd  (wb_data),
        .rd1 (src_a),
        .rd2 (src_b)
    );

    assign imm_ext = ctrl.sext ? {{16{imm16[15]}}, imm16} : {16'b0, imm16};
    assign alu_b   = ctrl.src_imm ? imm_ext : src_b;

    tcpu_alu #(.W(WORD_W)) u_alu (
        .a  (src_a),
        .b  (alu_b),
        .op (ctrl.alu_op),
        .y  (alu_y),
        .eq (alu_eq)
    );

    assign dmem_we = ctrl.mem_we;

    tcpu_dmem #(.W(WORD_W), .DEPTH(DMEM_DEPTH)) u_dm (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dmem_we),
        .idx   (alu_y[DMEM_AW+1:2]),
        .wd    (src_b),
        .rd    (mem_rd)
    );

    assign wr_idx  = ctrl.dst_rd ? rd : rt;
    assign wb_data = ctrl.mem_to_rf ? mem_rd : alu_y;

    // Next-PC: dedicated offset adder, independent of the ALU.
    assign pc_plus4   = pc_q + 32'd4;
    assign br_off     = {{14{imm16[15]}}, imm16, 2'b00};
    assign br_target  = pc_plus4 + br_off;
    assign jmp_target = {pc_q[31:28], imem_data[25:0], 2'b00};

    // Purpose: choose the successor PC.
    always_comb begin
        if (ctrl.is_jmp)                 pc_next = jmp_target;
        else if (ctrl.is_beq && alu_eq)  pc_next = br_target;
        else                             pc_next = pc_plus4;
    end

    // Purpose: program-counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    assign imem_addr   = pc_q[IMEM_AW+1:2];
    assign dbg_pc      = pc_q;
    assign dbg_wr_en   = ctrl.rf_we && (wr_idx != '0);
    assign dbg_wr_idx  = wr_idx;
    assign dbg_wr_data = wb_data;
endmodule

// File: rtl/tiny_cpu_chk.sv
// Checker for tiny_cpu, attached by bind. Observes the fetch and debug ports
// plus the data-memory write strobe.
module tiny_cpu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] imem_data,
    input logic [31:0] dbg_pc,
    input logic        dbg_wr_en,
    input logic [4:0]  dbg_wr_idx,
    input logic        dmem_we
);
    logic [5:0] op;
    assign op = imem_data[31:26];

    // R1: the first cycle out of reset fetches from address zero.
    p_reset_pc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> dbg_pc == 32'd0);

    // R2: anything other than a branch or a jump steps the PC by four.
    p_seq_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op != 6'b000100 && op != 6'b000010) |=> dbg_pc == $past(dbg_pc) + 32'd4);

    // R6: a store writes no register, and a memory write only comes from a store.
    p_store_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> (op == 6'b101011 && !dbg_wr_en));

    // R7: a branch never writes a register.
    p_beq_nowr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op == 6'b000100 |-> !dbg_wr_en && !dmem_we);

    // R8: a jump keeps the top PC nibble and takes the target field.
    p_jump_r8: assert property (@(posedge clk) disable iff (!rst_n)
        op == 6'b000010 |=> dbg_pc == {$past(dbg_pc[31:28]), $past(imem_data[25:0]), 2'b00});

    // R9: no visible write ever targets register zero.
    p_no_r0_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_wr_en |-> dbg_wr_idx != 5'd0);
endmodule

bind tiny_cpu tiny_cpu_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_data  (imem_data),
    .dbg_pc     (dbg_pc),
    .dbg_wr_en  (dbg_wr_en),
    .dbg_wr_idx (dbg_wr_idx),
    .dmem_we    (dmem_we)
);

// File: tb/sim_tiny_cpu.sv
// Bench: directed and pseudo-random programs compared per cycle with an
// instruction-level model built from the requirements.
module sim_tiny_cpu;
    localparam int IAW = 8;
    localparam int DD  = 16;
    localparam int IWORDS = 1 << IAW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [IAW-1:0] imem_addr;
    logic [31:0]    imem_data;
    logic [31:0]    dbg_pc;
    logic           dbg_wr_en;
    logic [4:0]     dbg_wr_idx;
    logic [31:0]    dbg_wr_data;

    logic [31:0] imem [IWORDS];
    logic [31:0] m_rf [32];
    logic [31:0] m_dm [DD];
    logic [31:0] m_pc;
    string       last_tag;
    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done    = 1'b0;
    logic [31:0] seed    = 32'h1234_5678;

    always #2 clk = ~clk;

    assign imem_data = imem[imem_addr];

    tiny_cpu #(.IMEM_AW(IAW), .DMEM_DEPTH(DD)) u0 (
        .clk (clk), .rst_n (rst_n), .imem_addr (imem_addr), .imem_data (imem_data),
        .dbg_pc (dbg_pc), .dbg_wr_en (dbg_wr_en), .dbg_wr_idx (dbg_wr_idx),
        .dbg_wr_data (dbg_wr_data)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    // Reference behaviour of one instruction, taken from R2..R10.
    task automatic model_step(output logic we, output logic [4:0] idx,
                              output logic [31:0] data, output string tag);
        logic [31:0] ins, a, b, sx, zx, addr, npc;
        logic        st;
        ins  = imem[m_pc[IAW+1:2]];
        a    = m_rf[ins[25:21]];
        b    = m_rf[ins[20:16]];
        sx   = {{16{ins[15]}}, ins[15:0]};
        zx   = {16'b0, ins[15:0]};
        addr = a + sx;
        npc  = m_pc + 32'd4;
        we = 1'b0; idx = 5'd0; data = 32'd0; st = 1'b0; tag = "R10";
        case (ins[31:26])
            6'b000000: begin
                idx = ins[15:11];
                if (ins[5:0] == 6'b100000)      begin we = 1'b1; data = a + b; tag = "R3"; end
                else if (ins[5:0] == 6'b100010) begin we = 1'b1; data = a - b; tag = "R3"; end
            end
            6'b001101: begin we = 1'b1; idx = ins[20:16]; data = a | zx; tag = "R4"; end
            6'b100011: begin we = 1'b1; idx = ins[20:16]; data = m_dm[addr[5:2]]; tag = "R5"; end
            6'b101011: begin st = 1'b1; tag = "R6"; end
            6'b000100: begin
                if (a == b) npc = m_pc + 32'd4 + {sx[29:0], 2'b00};
                tag = "R7";
            end
            6'b000010: begin npc = {m_pc[31:28], ins[25:0], 2'b00}; tag = "R8"; end
            default: ;
        endcase
        if (we && idx == 5'd0) begin we = 1'b0; tag = "R9"; end
        if (we) m_rf[idx] = data;
        if (st) m_dm[addr[5:2]] = b;
        m_pc = npc;
    endtask

    // R1: hold reset, check the PC, clear the model, release at a falling edge.
    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 pc in reset", dbg_pc, 32'd0);
        for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
        for (int i = 0; i < DD; i++) m_dm[i] = 32'd0;
        m_pc = 32'd0;
        last_tag = "R1";
        rst_n = 1'b1;
    endtask

    // R11: compare PC and debug write port each cycle, then let the edge commit.
    task automatic run_cycles(int n);
        logic we; logic [4:0] idx; logic [31:0] data; string tag;
        for (int c = 0; c < n; c++) begin
            check({last_tag, " next pc"}, dbg_pc, m_pc);
            model_step(we, idx, data, tag);
            check({tag, " R11 wr_en"}, {31'd0, dbg_wr_en}, {31'd0, we});
            if (we) begin
                check({tag, " R11 wr_idx"}, {27'd0, dbg_wr_idx}, {27'd0, idx});
                check({tag, " R11 wr_data"}, dbg_wr_data, data);
            end
            last_tag = (tag == "R7" || tag == "R8") ? tag : "R2";
            @(negedge clk);
        end
    endtask

    task automatic random_program();
        int k, rs, rt, rd;
        for (int i = 0; i < IWORDS; i++) begin
            k  = int'(rnd() % 32'd10);
            rs = int'(rnd() % 32'd8);
            rt = (rnd() % 32'd3 == 0) ? rs : int'(rnd() % 32'd8);
            rd = int'(rnd() % 32'd8);
            case (k)
                0: imem[i] = enc_r(rs, rt, rd, 6'b100000);
                1: imem[i] = enc_r(rs, rt, rd, 6'b100010);
                2, 3: imem[i] = enc_i(6'b001101, rs, rt, 16'(rnd()));
                4: imem[i] = enc_i(6'b100011, rs, rt, 16'(int'(rnd() % 32'd80) - 16));
                5: imem[i] = enc_i(6'b101011, rs, rt, 16'(int'(rnd() % 32'd80) - 16));
                6: imem[i] = enc_i(6'b000100, rs, rt, 16'(int'(rnd() % 32'd13) - 6));
                7: imem[i] = {6'b000010, 26'(rnd() % IWORDS)};
                8: imem[i] = {6'b111111, 26'(rnd())};
                default: imem[i] = enc_r(rs, rt, rd, 6'b100101);
            endcase
        end
    endtask

    initial begin
        for (int i = 0; i < IWORDS; i++) imem[i] = 32'd0;
        // Directed: store/load, r0 write, negative branch into the top of the
        // address space, and a jump that keeps PC[31:28] (R7, R8, R9, R5, R6).
        imem[0] = enc_i(6'b001101, 0, 1, 16'hFFFF);
        imem[1] = enc_i(6'b001101, 0, 2, 16'h0008);
        imem[2] = enc_i(6'b101011, 2, 1, 16'hFFFC);
        imem[3] = enc_i(6'b100011, 0, 3, 16'h0044);
        imem[4] = enc_r(1, 3, 0, 6'b100000);
        imem[5] = enc_r(3, 1, 4, 6'b100010);
        imem[6] = enc_i(6'b000100, 0, 0, 16'hFFF8);
        imem[255] = {6'b000010, 26'd9};
        imem[9]   = enc_i(6'b000100, 1, 2, 16'h0003);
        imem[10]  = enc_r(1, 2, 5, 6'b100000);
        do_reset();
        run_cycles(20);
        // Pseudo-random programs, each entered through a reset (R1 clears).
        for (int p = 0; p < 10; p++) begin
            rst_n = 1'b0;
            random_program();
            do_reset();
            run_cycles(500);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule